// File: doc/BRIEF.md
# Bounded Region Descriptor List Generator

This block turns one transfer request into a list of memory region descriptors for a scatter/gather DMA engine. The request gives a starting physical address, a total length and a direction. The length comes either as a byte count or as a sector count of 512-byte sectors. The block splits the buffer into regions of no more than 64 KiB, and no region crosses an aligned 64 KiB address boundary. It writes each region to memory as a pair of 32-bit words. The pairs are placed one after another, starting at a configured list base address.

The block writes one word at a time through a valid/ready write port. It holds `busy` high while the list is being built. When it finishes it raises `done` for one cycle and presents the number of descriptors it wrote. If the list would need more entries than its fixed limit, it sets an overflow flag instead. The direction is captured at start and held on an output, so the DMA engine can set up its own read/write control.

Top module: `region_list_gen`

## Requirements
- R1: Each region's length is the smallest of 65536, the bytes still remaining, and the distance from the region's start address to the next multiple of 65536. The next region starts at the address where the previous one ended.
- R2: The second word of a descriptor holds the length modulo 65536 in bits [15:0], so a full 64 KiB region encodes as 0. Bits [30:16] are zero. Bit 31 is set only on the descriptor that uses up the remaining bytes.
- R3: Descriptor k is written as two words. The region start address goes to list_base + 8k, then the length/flag word goes to list_base + 8k + 4. `mw_addr` and `mw_data` stay stable while `mw_valid` is high and `mw_ready` is low.
- R4: The list limit is (MAX_XFER / 65536 + 2) × 4 descriptors, which is 24 by default. If a further descriptor is needed once the limit is reached, generation stops after the 24th descriptor. The block then reports `overflow` = 1 and `desc_count` = 24, and none of the written descriptors has bit 31 set.
- R5: When `sector_mode` is 1 the total length is `sector_count` × 512 and `byte_count` is ignored. When it is 0 the total length is `byte_count`.
- R6: A total length of zero writes nothing. The block raises `done` in the cycle after `start`, with `desc_count` = 0 and `overflow` = 0, and `busy` stays low.
- R7: For a nonzero length, `busy` is high from the cycle after `start` until the last word write is accepted. `done` is a one-cycle pulse in the following cycle, and `busy` is low in that cycle. A `start` pulse while `busy` is high is ignored.
- R8: `xfer_to_dev` shows the `dir` value captured at the accepted `start` and holds it until the next accepted start.
- R9: During and just after reset, `busy`, `mw_valid`, `done`, `desc_count` and `overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new list (accepted only while idle) |
| start_addr | input | ADDR_W | Physical start address of the data buffer |
| byte_count | input | BYTE_W | Total length in bytes (byte mode) |
| sector_mode | input | 1 | 1: length is sector_count × 512 |
| sector_count | input | SECT_W | Number of 512-byte sectors |
| dir | input | 1 | Transfer direction, 1 = memory to device |
| list_base | input | ADDR_W | Address where the first descriptor is written |
| mw_valid | output | 1 | Write request valid |
| mw_ready | input | 1 | Write request accepted |
| mw_addr | output | ADDR_W | Write address |
| mw_data | output | 32 | Write data word |
| busy | output | 1 | List generation in progress |
| done | output | 1 | One-cycle completion pulse |
| desc_count | output | CNT_W | Descriptors written by the last job |
| overflow | output | 1 | Last job exceeded the descriptor limit |
| xfer_to_dev | output | 1 | Captured direction |

## Verification
A wrong remaining length or current address shows up on the very next length/flag word written. It appears as a wrong length, a misplaced end flag, or a region that crosses a 64 KiB boundary, and the same fault shifts the address word of the following descriptor. A wrong list pointer shows on `mw_addr` at the next accepted word. A corrupted descriptor counter shows at `done`, either as a wrong `desc_count` or as an overflow that comes too early or too late. The bench compares every accepted write, and `busy` on every clock, against its own model, so most faults are caught within a single descriptor.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_CNT  = 2'd2
    } gen_state_e;

    localparam int DESC_WORD_W = 32;

endpackage

// File: rtl/rlg_total_sel.sv
module rlg_total_sel #(
    parameter int BYTE_W     = 32,
    parameter int SECT_W     = 16,
    parameter int SECT_SHIFT = 9
) (
    input  logic              sector_mode,
    input  logic [BYTE_W-1:0] byte_count,
    input  logic [SECT_W-1:0] sector_count,
    output logic [BYTE_W-1:0] total
);
    localparam int SECT_BYTES_W = SECT_W + SECT_SHIFT;

    logic [SECT_BYTES_W-1:0] sect_bytes;

    always_comb begin
        sect_bytes = {sector_count, {SECT_SHIFT{1'b0}}};
        if (sector_mode) begin
            total = BYTE_W'(sect_bytes);
        end else begin
            total = byte_count;
        end
    end
endmodule

// File: rtl/rlg_region_calc.sv
module rlg_region_calc #(
    parameter int ADDR_W      = 32,
    parameter int BYTE_W      = 32,
    parameter int REGION_LOG2 = 16
) (
    input  logic [ADDR_W-1:0]      cur_addr,
    input  logic [BYTE_W-1:0]      remaining,
    output logic [REGION_LOG2:0]   len,
    output logic                   is_last,
    output logic [31:0]            count_word
);
    localparam int LEN_W     = REGION_LOG2 + 1;
    localparam int FULL      = 1 << REGION_LOG2;
    localparam int PAD_W     = 31 - REGION_LOG2;

    logic [LEN_W-1:0] to_boundary;
    logic [LEN_W-1:0] capped;

    always_comb begin
        // distance to next aligned region boundary, range 1..FULL
        to_boundary = LEN_W'(FULL) - {1'b0, cur_addr[REGION_LOG2-1:0]};
        if (remaining > BYTE_W'(FULL)) begin
            capped = LEN_W'(FULL);
        end else begin
            capped = remaining[LEN_W-1:0];
        end
        len        = (to_boundary < capped) ? to_boundary : capped;
        is_last    = (remaining == BYTE_W'(len));
        count_word = {is_last, {PAD_W{1'b0}}, len[REGION_LOG2-1:0]};
    end
endmodule

// File: rtl/region_list_gen.sv
module region_list_gen #(
    parameter int ADDR_W      = 32,
    parameter int BYTE_W      = 32,
    parameter int SECT_W      = 16,
    parameter int SECT_SHIFT  = 9,
    parameter int REGION_LOG2 = 16,
    parameter int MAX_XFER    = 262144,
    parameter int MAX_DESC    = (MAX_XFER / (1 << REGION_LOG2) + 2) * 4,
    parameter int CNT_W       = $clog2(MAX_DESC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [BYTE_W-1:0] byte_count,
    input  logic              sector_mode,
    input  logic [SECT_W-1:0] sector_count,
    input  logic              dir,
    input  logic [ADDR_W-1:0] list_base,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [31:0]       mw_data,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  desc_count,
    output logic              overflow,
    output logic              xfer_to_dev
);
    import rlg_pkg::*;

    localparam int LEN_W = REGION_LOG2 + 1;

    typedef struct packed {
        gen_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] cur;
        logic [BYTE_W-1:0] rem;
        logic [CNT_W-1:0]  n;
        logic              ovf;
        logic              done;
        logic              dir;
    } gen_regs_t;

    gen_regs_t regs_q, regs_d;

    logic [BYTE_W-1:0] total;
    logic [LEN_W-1:0]  len;
    logic              is_last;
    logic [31:0]       count_word;

    rlg_total_sel #(
        .BYTE_W     (BYTE_W),
        .SECT_W     (SECT_W),
        .SECT_SHIFT (SECT_SHIFT)
    ) u_total (
        .sector_mode  (sector_mode),
        .byte_count   (byte_count),
        .sector_count (sector_count),
        .total        (total)
    );

    rlg_region_calc #(
        .ADDR_W      (ADDR_W),
        .BYTE_W      (BYTE_W),
        .REGION_LOG2 (REGION_LOG2)
    ) u_region (
        .cur_addr   (regs_q.cur),
        .remaining  (regs_q.rem),
        .len        (len),
        .is_last    (is_last),
        .count_word (count_word)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start) begin
                    regs_d.ptr = list_base;
                    regs_d.cur = start_addr;
                    regs_d.rem = total;
                    regs_d.n   = '0;
                    regs_d.ovf = 1'b0;
                    regs_d.dir = dir;
                    if (total == '0) begin
                        regs_d.done = 1'b1;
                    end else begin
                        regs_d.st = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                if (mw_ready) begin
                    regs_d.ptr = regs_q.ptr + ADDR_W'(4);
                    regs_d.st  = ST_CNT;
                end
            end
            ST_CNT: begin
                if (mw_ready) begin
                    regs_d.ptr = regs_q.ptr + ADDR_W'(4);
                    regs_d.cur = regs_q.cur + ADDR_W'(len);
                    regs_d.rem = regs_q.rem - BYTE_W'(len);
                    regs_d.n   = regs_q.n + CNT_W'(1);
                    if (is_last) begin
                        regs_d.st   = ST_IDLE;
                        regs_d.done = 1'b1;
                    end else if (regs_q.n + CNT_W'(1) == CNT_W'(MAX_DESC)) begin
                        regs_d.st   = ST_IDLE;
                        regs_d.ovf  = 1'b1;
                        regs_d.done = 1'b1;
                    end else begin
                        regs_d.st = ST_ADDR;
                    end
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mw_valid    = (regs_q.st != ST_IDLE);
    assign busy        = (regs_q.st != ST_IDLE);
    assign mw_addr     = regs_q.ptr;
    assign mw_data     = (regs_q.st == ST_CNT) ? count_word : DESC_WORD_W'(regs_q.cur);
    assign done        = regs_q.done;
    assign desc_count  = regs_q.n;
    assign overflow    = regs_q.ovf;
    assign xfer_to_dev = regs_q.dir;

endmodule

// File: rtl/region_list_gen_chk.sv
module region_list_gen_chk #(
    parameter int ADDR_W   = 32,
    parameter int BYTE_W   = 32,
    parameter int CNT_W    = 5,
    parameter int MAX_DESC = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [BYTE_W-1:0] byte_count,
    input logic              sector_mode,
    input logic              mw_valid,
    input logic              mw_ready,
    input logic [ADDR_W-1:0] mw_addr,
    input logic [31:0]       mw_data,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  desc_count,
    input logic              overflow
);
    // R9: quiet outputs one cycle into reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mw_valid && !done && desc_count == '0 && !overflow));

    // R3: write request held until accepted
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    // R7: done is a single-cycle pulse with busy low
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: nonzero byte job goes busy next cycle
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !sector_mode && byte_count != '0) |=> busy);

    // R6: zero-length byte job completes at once
    a_r6_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !sector_mode && byte_count == '0)
        |=> (done && !busy && desc_count == '0 && !overflow));

    // R4: count never exceeds the limit, overflow reports a full list
    a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        desc_count <= CNT_W'(MAX_DESC));
    a_r4_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (desc_count == CNT_W'(MAX_DESC)));

endmodule

bind region_list_gen region_list_gen_chk #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .CNT_W    (CNT_W),
    .MAX_DESC (MAX_DESC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .byte_count  (byte_count),
    .sector_mode (sector_mode),
    .mw_valid    (mw_valid),
    .mw_ready    (mw_ready),
    .mw_addr     (mw_addr),
    .mw_data     (mw_data),
    .busy        (busy),
    .done        (done),
    .desc_count  (desc_count),
    .overflow    (overflow)
);

// File: tb/region_list_gen_bench.sv
module region_list_gen_bench;
    localparam int MAXD = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [31:0] byte_count = '0;
    logic        sector_mode = 1'b0;
    logic [15:0] sector_count = '0;
    logic        dir = 1'b0;
    logic [31:0] list_base = '0;
    logic        mw_valid;
    logic        mw_ready = 1'b0;
    logic [31:0] mw_addr;
    logic [31:0] mw_data;
    logic        busy;
    logic        done;
    logic [4:0]  desc_count;
    logic        overflow;
    logic        xfer_to_dev;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rdy_mode = 0;

    logic [63:0] exp_q[$];
    int          exp_n = 0;
    logic        exp_ovf = 1'b0;
    logic        exp_dir = 1'b0;
    logic        exp_busy = 1'b0;
    logic        job_done = 1'b0;

    region_list_gen u_region_list_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .sector_mode(sector_mode),
        .sector_count(sector_count), .dir(dir), .list_base(list_base),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
        .mw_data(mw_data), .busy(busy), .done(done),
        .desc_count(desc_count), .overflow(overflow), .xfer_to_dev(xfer_to_dev)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL R7 watchdog act=%0d exp=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // reference comparison at every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            case (rdy_mode)
                0: mw_ready = 1'b1;
                1: mw_ready = ($urandom % 3) != 0;
                default: mw_ready = ($urandom % 4) == 0;
            endcase
            if (mw_valid && mw_ready) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected write", 64'(mw_addr), 64'hFFFF_FFFF_FFFF);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    check("R3 word address", 64'(mw_addr), 64'(e[63:32]));
                    check("R1 R2 word data", 64'(mw_data), 64'(e[31:0]));
                end
            end
            if (done) begin
                check("R7 busy low at done", 64'(busy), 64'd0);
                check("R4 descriptor count", 64'(desc_count), 64'(exp_n));
                check("R4 overflow flag", 64'(overflow), 64'(exp_ovf));
                check("R3 all words written", 64'(exp_q.size()), 64'd0);
                check("R8 direction", 64'(xfer_to_dev), 64'(exp_dir));
                exp_busy = 1'b0;
                job_done = 1'b1;
            end else begin
                check("R7 busy", 64'(busy), 64'(exp_busy));
            end
        end
    end

    task automatic run_job(input logic [31:0] a0, input logic [31:0] bytes,
                           input logic smode, input logic [15:0] scount,
                           input logic [31:0] base, input logic d,
                           input int rmode, input logic poke);
        longint rem, a, len;
        logic [31:0] w;
        int n;
        rem = smode ? longint'(scount) * 512 : longint'(bytes);
        a = a0;
        n = 0;
        exp_ovf = 1'b0;
        exp_q.delete();
        while (rem > 0) begin
            if (n >= MAXD) begin
                exp_ovf = 1'b1;
                break;
            end
            len = (rem > 65536) ? 65536 : rem;
            if (((a + len - 1) >> 16) != (a >> 16)) len = 65536 - (a & 64'hFFFF);
            w = 32'(len & 64'hFFFF) | ((rem == len) ? 32'h8000_0000 : 32'h0);
            exp_q.push_back({32'(base + 32'(8 * n)), 32'(a)});
            exp_q.push_back({32'(base + 32'(8 * n + 4)), w});
            rem = rem - len;
            a = (a + len) & 64'hFFFF_FFFF;
            n++;
        end
        exp_n = n;
        exp_dir = d;
        rdy_mode = rmode;
        job_done = 1'b0;
        @(negedge clk);
        start_addr = a0; byte_count = bytes; sector_mode = smode;
        sector_count = scount; list_base = base; dir = d; start = 1'b1;
        @(posedge clk);
        exp_busy = (n != 0) || exp_ovf;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            // R7: start while busy must be ignored
            start_addr = 32'hDEAD_0000; byte_count = 32'h10; list_base = 32'h0;
            dir = ~d; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 5000; i++) begin
            if (job_done) break;
            @(negedge clk);
        end
        if (!job_done) check("R7 job completion", 64'd0, 64'd1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 busy", 64'(busy), 64'd0);
        check("R9 mw_valid", 64'(mw_valid), 64'd0);
        check("R9 done", 64'(done), 64'd0);
        check("R9 desc_count", 64'(desc_count), 64'd0);
        check("R9 overflow", 64'(overflow), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2: single region
        run_job(32'h1234_0000, 32'h1000, 1'b0, 16'd0, 32'h0000_8000, 1'b0, 0, 1'b0);
        // R1: crossing a 64 KiB boundary
        run_job(32'h0001_FF00, 32'h300, 1'b0, 16'd0, 32'h0000_9000, 1'b1, 1, 1'b0);
        // R2: full aligned regions encode as zero
        run_job(32'h0010_0000, 32'h2_0000, 1'b0, 16'd0, 32'h0000_A000, 1'b0, 1, 1'b0);
        // R1: unaligned large buffer
        run_job(32'h0000_8000, 32'h3_0000, 1'b0, 16'd0, 32'h0002_0000, 1'b1, 2, 1'b0);
        // R5: sector mode, byte_count ignored
        run_job(32'h4000_1234, 32'h5, 1'b1, 16'd300, 32'h0003_0000, 1'b1, 1, 1'b0);
        // R6: zero length
        run_job(32'h0000_1000, 32'h0, 1'b0, 16'd0, 32'h0004_0000, 1'b1, 0, 1'b0);
        // R5 R6: sector mode with zero sectors, nonzero byte_count
        run_job(32'h0000_1000, 32'h400, 1'b1, 16'd0, 32'h0004_0000, 1'b0, 0, 1'b0);
        // R4: exactly at limit
        run_job(32'h0100_0000, 32'h18_0000, 1'b0, 16'd0, 32'h0005_0000, 1'b0, 1, 1'b0);
        // R4: overflow
        run_job(32'h0200_0000, 32'h20_0000, 1'b0, 16'd0, 32'h0006_0000, 1'b1, 1, 1'b0);
        // R7 R8: start while busy ignored
        run_job(32'h0000_F000, 32'h2_2000, 1'b0, 16'd0, 32'h0007_0000, 1'b1, 2, 1'b1);
        // R1: address wrap at top of space
        run_job(32'hFFFF_8000, 32'h1_0000, 1'b0, 16'd0, 32'h0008_0000, 1'b0, 0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule